// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

This block turns a decimal digit, presented one bit per clock on a single serial input, into its excess-3 code on a single serial output. Each incoming BCD digit is four bits long and arrives least significant bit first. For every accepted input bit the block produces the matching output bit in the same cycle, so the converted digit leaves the block in step with the digit that enters it.

Internally the add-three is done bit by bit by a small Mealy machine with three state flip-flops. Two of them walk through the four bit positions of a digit in Gray order. The third carries the running carry of the addition, stored true or inverted depending on the position. Every next-state function and the output are two-level sums of products over the serial input and the three state bits. The logic therefore maps directly onto a registered AND-OR array, and each plane in the RTL is described only by its literal masks. A strobe qualifies each input bit, so the upstream source may pause between bits or between digits.

Top module: `bcd_xs3_serial`

## Requirements
- R1: A synchronous reset, sampled on the rising clock edge, puts the machine in its start state. The next accepted bit is treated as bit 0 of a new digit, and for that bit `z_out` equals the inverse of `x_in`.
- R2: Digits enter LSB first, four accepted bits per digit. For each digit value 0 to 9, the four `z_out` bits, taken in the same order (first bit = weight 1, fourth bit = weight 8), equal the digit plus 3 as a 4-bit value.
- R3: After the fourth accepted bit of a digit the machine is back in its start state with the carry cleared. The next digit can follow in the very next cycle, with no idle cycle.
- R4: In a cycle where `bit_valid` is low the state holds and `x_in` has no effect. The conversion resumes at the same bit position with the same carry.
- R5: `z_out` is a combinational function of the present `x_in` and the present state (Mealy): a change of `x_in` shows on `z_out` within the same cycle. The state bits are not driven out of the block.
- R6: A reset in the middle of a digit discards the partial digit. The following four accepted bits are converted as a fresh digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset to the start state, active high |
| bit_valid | input | 1 | High when `x_in` carries a digit bit to be consumed this cycle |
| x_in | input | 1 | Serial BCD input, LSB first |
| z_out | output | 1 | Serial excess-3 output, meaningful in cycles where `bit_valid` is high |

## Verification
The block has no parameters to vary. The product-term masks come from the package, so the bench builds the single fixed equation set and drives it through every reachable state. Streaming all ten digits back to back covers every carry path of the add-three, including the wrap from the last bit position straight into the next digit. Stalled cycles with toggling junk input, a reset in the middle of a digit, and a same-cycle toggle of the input in the start state cover the hold, the abort and the Mealy path.

// File: rtl/bcdx3_pkg.sv
package bcdx3_pkg;

    // Literal vector feeding every AND plane: {x, q1, q2, q3}
    localparam int unsigned LIT_W   = 4;
    localparam int unsigned LIT_X   = 3;
    localparam int unsigned LIT_Q1  = 2;
    localparam int unsigned LIT_Q2  = 1;
    localparam int unsigned LIT_Q3  = 0;

    localparam int unsigned DIGIT_BITS = 4;

    typedef struct packed {
        logic q1;
        logic q2;
        logic q3;
    } cvt_state_t;

    localparam cvt_state_t ST_START = '{q1: 1'b0, q2: 1'b0, q3: 1'b0};

    // Q1 next = Q2'
    localparam int unsigned Q1_TERMS = 1;
    localparam logic [Q1_TERMS-1:0][LIT_W-1:0] Q1_TRUE = {4'b0000};
    localparam logic [Q1_TERMS-1:0][LIT_W-1:0] Q1_COMP = {4'b0010};

    // Q2 next = Q1
    localparam int unsigned Q2_TERMS = 1;
    localparam logic [Q2_TERMS-1:0][LIT_W-1:0] Q2_TRUE = {4'b0100};
    localparam logic [Q2_TERMS-1:0][LIT_W-1:0] Q2_COMP = {4'b0000};

    // Q3 next = Q1.Q2.Q3 + X'.Q1.Q3' + X.Q1'.Q2'
    localparam int unsigned Q3_TERMS = 3;
    localparam logic [Q3_TERMS-1:0][LIT_W-1:0] Q3_TRUE = {4'b1000, 4'b0100, 4'b0111};
    localparam logic [Q3_TERMS-1:0][LIT_W-1:0] Q3_COMP = {4'b0110, 4'b1001, 4'b0000};

    // Z = X.Q3 + X'.Q3'
    localparam int unsigned Z_TERMS = 2;
    localparam logic [Z_TERMS-1:0][LIT_W-1:0] Z_TRUE = {4'b0000, 4'b1001};
    localparam logic [Z_TERMS-1:0][LIT_W-1:0] Z_COMP = {4'b1001, 4'b0000};

endpackage

// File: rtl/sop_plane.sv
// One OR gate fed by N_TERMS AND gates. Each AND gate takes a literal in
// true form where its TRUE mask bit is set, in complement form where its
// COMP mask bit is set, and ignores the input otherwise.
module sop_plane #(
    parameter int unsigned N_IN    = 4,
    parameter int unsigned N_TERMS = 1,
    parameter logic [N_TERMS-1:0][N_IN-1:0] LIT_TRUE = '0,
    parameter logic [N_TERMS-1:0][N_IN-1:0] LIT_COMP = '0
) (
    input  logic [N_IN-1:0] lits,
    output logic            sum
);

    logic [N_TERMS-1:0] prod;

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        assign prod[t] = &((lits | ~LIT_TRUE[t]) & (~lits | ~LIT_COMP[t]));
    end

    assign sum = |prod;

endmodule

// File: rtl/bcd_xs3_serial.sv
module bcd_xs3_serial
    import bcdx3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic x_in,
    output logic z_out
);

    cvt_state_t state_q, state_d;
    logic [LIT_W-1:0] lits;
    logic nq1, nq2, nq3;

    always_comb begin
        lits         = '0;
        lits[LIT_X]  = x_in;
        lits[LIT_Q1] = state_q.q1;
        lits[LIT_Q2] = state_q.q2;
        lits[LIT_Q3] = state_q.q3;
    end

    sop_plane #(.N_IN(LIT_W), .N_TERMS(Q1_TERMS), .LIT_TRUE(Q1_TRUE), .LIT_COMP(Q1_COMP))
        u_plane_q1 (.lits(lits), .sum(nq1));

    sop_plane #(.N_IN(LIT_W), .N_TERMS(Q2_TERMS), .LIT_TRUE(Q2_TRUE), .LIT_COMP(Q2_COMP))
        u_plane_q2 (.lits(lits), .sum(nq2));

    sop_plane #(.N_IN(LIT_W), .N_TERMS(Q3_TERMS), .LIT_TRUE(Q3_TRUE), .LIT_COMP(Q3_COMP))
        u_plane_q3 (.lits(lits), .sum(nq3));

    sop_plane #(.N_IN(LIT_W), .N_TERMS(Z_TERMS), .LIT_TRUE(Z_TRUE), .LIT_COMP(Z_COMP))
        u_plane_z (.lits(lits), .sum(z_out));

    always_comb begin
        state_d = state_q;
        if (bit_valid) begin
            state_d.q1 = nq1;
            state_d.q2 = nq2;
            state_d.q3 = nq3;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_START;
        else     state_q <= state_d;
    end

    // R1: the cycle after reset is released, the machine sits in the start state
    assert_reset_start_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (state_q == ST_START));

    // R4: a stalled cycle leaves every state bit untouched
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> $stable(state_q));

    // R3: an accepted bit in the last position returns the machine to start
    assert_digit_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && !state_q.q1 && state_q.q2) |=> (state_q == ST_START));

    // R3: at the first bit position no carry is pending
    assert_start_no_carry_R3: assert property (@(posedge clk) disable iff (rst)
        (!state_q.q1 && !state_q.q2) |-> !state_q.q3);

    // R5: at bit 0 the output plane inverts the input in the same cycle
    assert_bit0_mealy_R5: assert property (@(posedge clk) disable iff (rst)
        (!state_q.q1 && !state_q.q2) |-> (z_out == !x_in));

endmodule

// File: tb/tb_bcd_xs3_serial.sv
module tb_bcd_xs3_serial;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_valid = 1'b0;
    logic x_in = 1'b0;
    logic z_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bcd_xs3_serial dut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .x_in(x_in), .z_out(z_out)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bit_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive one accepted bit at the falling edge, sample z just before the rise.
    task automatic send_bit(input logic b, input int exp_z, input string req, output logic zs);
        @(negedge clk);
        bit_valid = 1'b1;
        x_in = b;
        #3;
        zs = z_out;
        check(req, int'(zs), exp_z);
    endtask

    task automatic stall(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_valid = 1'b0;
            x_in = ~x_in;
        end
    endtask

    // Reference: excess-3 bits from the digit value, serial LSB first.
    task automatic send_digit(input int d, input int gap, input string req);
        int expect_code;
        int got;
        logic zs;
        expect_code = (d + 3) & 15;
        got = 0;
        for (int k = 0; k < 4; k++) begin
            send_bit(d[k], (expect_code >> k) & 1, req, zs);
            got = got | (int'(zs) << k);
            if (gap > 0) stall(gap);
        end
        check({req, " nibble"}, got, expect_code);
    endtask

    initial begin
        logic zs;
        do_reset();

        // R1: first bit after reset is bit 0, z is ~x
        @(negedge clk);
        bit_valid = 1'b0; x_in = 1'b0;
        #3; check("R1 start z for x=0", int'(z_out), 1);
        // R5: toggle x within the same cycle, no clock in between
        x_in = 1'b1;
        #1; check("R5 same-cycle z for x=1", int'(z_out), 0);
        x_in = 1'b0;
        #1; check("R5 same-cycle z back for x=0", int'(z_out), 1);

        // R2/R3: all ten digits back to back, no idle cycle
        for (int d = 0; d < 10; d++) send_digit(d, 0, "R2 R3 back-to-back");

        // R4: stalls with toggling junk on x between every bit
        for (int d = 9; d >= 0; d--) send_digit(d, 2, "R4 stalled");

        // R6: abandon a digit after two bits, then a fresh digit
        send_bit(1'b1, 0, "R6 partial bit0", zs);
        send_bit(1'b1, 1, "R6 partial bit1", zs);
        do_reset();
        send_digit(5, 0, "R6 after mid-digit reset");
        send_digit(8, 1, "R6 follow-on");

        // R1: reset during a stall, then digit 0
        send_bit(1'b0, 1, "R1 partial bit0", zs);
        stall(1);
        do_reset();
        send_digit(0, 0, "R1 after reset");

        @(negedge clk);
        bit_valid = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule